// File: doc/BRIEF.md
# Framed Packet Transmit Encoder

This block turns one request (field values plus a payload held in a small external byte buffer) into a framed byte stream on a valid/ready output. Each frame starts with a fixed start byte and a version/length word. A CRC-8 over those first three bytes follows. Next come the addressing and command fields, whose layout depends on whether the frame is for a point-to-point link or a shared bus. The payload bytes come after that, and a CRC-16 over every earlier byte closes the frame.

The request side is a single valid/ready handshake. The encoder latches the fields when it accepts a request and works out the total frame length from the layout and the payload size. It then walks the frame one byte per accepted output beat. It reads payload bytes through an address/data port, and that read must return data in the same cycle. Both CRC accumulators advance on the beat that carries each byte, so the trailer follows the last payload byte with no gap.

Top module: `pkt_frame_tx`

## Requirements
- R1: Byte 0 of every frame is 0x55.
- R2: The frame length L is 12+n in point-to-point layout and 7+n in bus layout, where n is the payload size. Byte 1 is L[7:0] and byte 2 is {version[5:0], L[9:8]}, with version 1 for point-to-point and 0 for bus. Exactly L bytes are sent, and `out_last` is high only on the last one.
- R3: Byte 3 is a CRC-8 over bytes 0 to 2: most significant bit first, polynomial 0x07, initial value 0xFE, no final inversion.
- R4: The command-type byte carries the packet type in bit 7 (0 request, 1 response) and the need-acknowledge flag in bit 6. Bits 5 to 0 are zero.
- R5: In point-to-point layout, bytes 4 to 9 are sender, receiver, sequence high byte, sequence low byte, command-type byte and command ID, in that order.
- R6: In bus layout, byte 4 is the command ID and payload begins at byte 5. No sender, receiver, sequence or command-type byte is sent.
- R7: Payload byte k is read from buffer address k and sent at header length plus k. A zero-length payload is legal, and the largest is MAX_PAYLOAD bytes.
- R8: The last two bytes are a CRC-16 over all earlier bytes, low byte first: most significant bit first, polynomial 0x1021, initial value 0xFEFE, no final inversion.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_last` hold their values.
- R10: `req_ready` is low from the cycle after a request is accepted until the final byte is accepted, and is high again in the next cycle.
- R11: Reset, including reset in the middle of a frame, leaves `out_valid` low and `req_ready` high once reset is released. The next frame after that is complete and correct.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Encoder idle and able to take a request |
| req_layout | input | 1 | 1 point-to-point, 0 bus |
| req_is_resp | input | 1 | Packet type: 1 response, 0 request |
| req_need_ack | input | 1 | Need-acknowledge flag |
| req_cmd | input | 8 | Command ID |
| req_sender | input | 8 | Sender ID (point-to-point only) |
| req_receiver | input | 8 | Receiver ID (point-to-point only) |
| req_seq | input | 16 | Sequence number (point-to-point only) |
| req_plen | input | PLEN_W (9) | Payload size in bytes, 0 to MAX_PAYLOAD |
| pl_raddr | output | PADDR_W (8) | Payload buffer read address |
| pl_rdata | input | 8 | Payload byte at `pl_raddr`, same cycle |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream accepts the byte |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Final byte of the frame |

## Verification
The bench covers both layouts with an empty payload and with a full MAX_PAYLOAD payload. The full payload pushes the length past 255, so a design that drops L[9:8] from byte 2, or starts the payload at the wrong offset in bus layout, shows wrong header bytes or a wrong byte count. Back-pressure patterns that stall on header, payload and trailer bytes catch CRC engines that advance on `out_valid` alone. They also catch a CRC-16 that keeps running through its own trailer: both show up as wrong CRC bytes. A reset in the middle of a frame followed by a clean frame exposes accumulators or counters that are not reinitialised.

// File: rtl/pkt_frame_pkg.sv
package pkt_frame_pkg;
  typedef enum logic {LAYOUT_BUS = 1'b0, LAYOUT_P2P = 1'b1} layout_e;
  typedef enum logic {ST_IDLE = 1'b0, ST_SEND = 1'b1} seq_state_e;

  localparam logic [7:0] SOF_BYTE = 8'h55;
  localparam int P2P_HDR_BYTES = 10;
  localparam int BUS_HDR_BYTES = 5;
  localparam int TRAILER_BYTES = 2;
  localparam int LEN_W         = 10;

  typedef struct packed {
    layout_e     layout;
    logic        is_resp;
    logic        need_ack;
    logic [7:0]  cmd;
    logic [7:0]  sender;
    logic [7:0]  receiver;
    logic [15:0] seq;
  } req_fields_t;
endpackage

// File: rtl/pkt_rst_sync.sv
module pkt_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/pkt_crc_acc.sv
module pkt_crc_acc #(
  parameter int           W    = 8,
  parameter logic [W-1:0] POLY = '0,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic [7:0]   din,
  output logic [W-1:0] crc
);
  logic [W-1:0] crc_q, crc_d;

  function automatic logic [W-1:0] crc_step(input logic [W-1:0] c, input logic [7:0] d);
    logic [W-1:0] r;
    logic         fb;
    r = c;
    for (int b = 7; b >= 0; b--) begin
      fb = r[W-1] ^ d[b];
      r  = {r[W-2:0], 1'b0};
      if (fb) r = r ^ POLY;
    end
    return r;
  endfunction

  always_comb begin
    crc_d = crc_q;
    if (clr)     crc_d = INIT;
    else if (en) crc_d = crc_step(crc_q, din);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= INIT;
    else        crc_q <= crc_d;
  end

  assign crc = crc_q;
endmodule

// File: rtl/pkt_len_calc.sv
module pkt_len_calc
  import pkt_frame_pkg::*;
#(
  parameter int PLEN_W = 9
) (
  input  layout_e          layout,
  input  logic [PLEN_W-1:0] plen,
  output logic [LEN_W-1:0]  frame_len,
  output logic [LEN_W-1:0]  hdr_len
);
  localparam logic [LEN_W-1:0] P2P_HDR = LEN_W'(P2P_HDR_BYTES);
  localparam logic [LEN_W-1:0] BUS_HDR = LEN_W'(BUS_HDR_BYTES);
  localparam logic [LEN_W-1:0] TRAIL   = LEN_W'(TRAILER_BYTES);

  always_comb begin
    hdr_len   = (layout == LAYOUT_P2P) ? P2P_HDR : BUS_HDR;
    frame_len = hdr_len + LEN_W'(plen) + TRAIL;
  end
endmodule

// File: rtl/pkt_frame_seq.sv
module pkt_frame_seq
  import pkt_frame_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             beat,
  input  logic [LEN_W-1:0] frame_len,
  output logic             busy,
  output logic [LEN_W-1:0] idx,
  output logic             is_last
);
  seq_state_e       st_q, st_d;
  logic [LEN_W-1:0] idx_q, idx_d;

  assign is_last = (idx_q == frame_len - LEN_W'(1));

  always_comb begin
    st_d  = st_q;
    idx_d = idx_q;
    case (st_q)
      ST_IDLE: if (start) begin
        st_d  = ST_SEND;
        idx_d = '0;
      end
      ST_SEND: if (beat) begin
        if (is_last) st_d = ST_IDLE;
        else         idx_d = idx_q + LEN_W'(1);
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      idx_q <= '0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
    end
  end

  assign busy = (st_q == ST_SEND);
  assign idx  = idx_q;
endmodule

// File: rtl/pkt_frame_tx.sv
module pkt_frame_tx
  import pkt_frame_pkg::*;
#(
  parameter int          MAX_PAYLOAD = 256,
  parameter logic [7:0]  CRC8_POLY   = 8'h07,
  parameter logic [7:0]  CRC8_INIT   = 8'hFE,
  parameter logic [15:0] CRC16_POLY  = 16'h1021,
  parameter logic [15:0] CRC16_INIT  = 16'hFEFE,
  localparam int PLEN_W  = $clog2(MAX_PAYLOAD + 1),
  localparam int PADDR_W = $clog2(MAX_PAYLOAD)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_layout,
  input  logic               req_is_resp,
  input  logic               req_need_ack,
  input  logic [7:0]         req_cmd,
  input  logic [7:0]         req_sender,
  input  logic [7:0]         req_receiver,
  input  logic [15:0]        req_seq,
  input  logic [PLEN_W-1:0]  req_plen,
  output logic [PADDR_W-1:0] pl_raddr,
  input  logic [7:0]         pl_rdata,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [7:0]         out_data,
  output logic               out_last
);
  logic             rst_ok;
  logic             accept, beat, busy, is_last;
  logic [LEN_W-1:0] idx, frame_len, hdr_len, pl_off;
  logic [7:0]       crc8;
  logic [15:0]      crc16;
  req_fields_t      f_q, f_d;
  logic [PLEN_W-1:0] plen_q, plen_d;
  logic [7:0]       cmd_type;

  pkt_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_ok));

  assign req_ready = rst_ok && !busy;
  assign accept    = req_valid && req_ready;
  assign out_valid = busy;
  assign beat      = out_valid && out_ready;
  assign out_last  = busy && is_last;

  // request field capture, enabled by accept
  always_comb begin
    f_d    = f_q;
    plen_d = plen_q;
    if (accept) begin
      f_d.layout   = layout_e'(req_layout);
      f_d.is_resp  = req_is_resp;
      f_d.need_ack = req_need_ack;
      f_d.cmd      = req_cmd;
      f_d.sender   = req_sender;
      f_d.receiver = req_receiver;
      f_d.seq      = req_seq;
      plen_d       = req_plen;
    end
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      f_q    <= '0;
      plen_q <= '0;
    end else begin
      f_q    <= f_d;
      plen_q <= plen_d;
    end
  end

  pkt_len_calc #(.PLEN_W(PLEN_W)) u_len (
    .layout(f_q.layout), .plen(plen_q), .frame_len(frame_len), .hdr_len(hdr_len)
  );

  pkt_frame_seq u_seq (
    .clk(clk), .rst_n(rst_ok), .start(accept), .beat(beat), .frame_len(frame_len),
    .busy(busy), .idx(idx), .is_last(is_last)
  );

  pkt_crc_acc #(.W(8), .POLY(CRC8_POLY), .INIT(CRC8_INIT)) u_crc8 (
    .clk(clk), .rst_n(rst_ok), .clr(accept),
    .en(beat && (idx < LEN_W'(3))), .din(out_data), .crc(crc8)
  );

  pkt_crc_acc #(.W(16), .POLY(CRC16_POLY), .INIT(CRC16_INIT)) u_crc16 (
    .clk(clk), .rst_n(rst_ok), .clr(accept),
    .en(beat && (idx < frame_len - LEN_W'(TRAILER_BYTES))), .din(out_data), .crc(crc16)
  );

  assign pl_off   = idx - hdr_len;
  assign pl_raddr = pl_off[PADDR_W-1:0];
  assign cmd_type = {f_q.is_resp, f_q.need_ack, 6'b000000};

  always_comb begin
    out_data = 8'h00;
    if (idx == LEN_W'(0))      out_data = SOF_BYTE;
    else if (idx == LEN_W'(1)) out_data = frame_len[7:0];
    else if (idx == LEN_W'(2)) out_data = {5'b00000, f_q.layout, frame_len[9:8]};
    else if (idx == LEN_W'(3)) out_data = crc8;
    else if (idx == frame_len - LEN_W'(2)) out_data = crc16[7:0];
    else if (idx == frame_len - LEN_W'(1)) out_data = crc16[15:8];
    else if (idx >= hdr_len)   out_data = pl_rdata;
    else if (f_q.layout == LAYOUT_P2P) begin
      case (idx[3:0])
        4'd4:    out_data = f_q.sender;
        4'd5:    out_data = f_q.receiver;
        4'd6:    out_data = f_q.seq[15:8];
        4'd7:    out_data = f_q.seq[7:0];
        4'd8:    out_data = cmd_type;
        4'd9:    out_data = f_q.cmd;
        default: out_data = 8'h00;
      endcase
    end else begin
      out_data = f_q.cmd;
    end
  end
endmodule

// File: rtl/pkt_frame_tx_chk.sv
module pkt_frame_tx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_ready,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic       out_last
);
  logic [9:0] cnt_q, len_q;
  logic       beat;
  assign beat = out_valid && out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      len_q <= '0;
    end else if (beat) begin
      cnt_q <= out_last ? 10'd0 : cnt_q + 10'd1;
      if (cnt_q == 10'd1) len_q[7:0] <= out_data;
      if (cnt_q == 10'd2) len_q[9:8] <= out_data[1:0];
    end
  end

  a_r1_sof_first: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && cnt_q == 10'd0) |-> out_data == 8'h55);

  a_r2_last_matches_len: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_last) |-> (cnt_q + 10'd1) == len_q);

  a_r9_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

  a_r10_busy_blocks_req: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !req_ready);

  a_r10_ready_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && out_last) |=> (req_ready && !out_valid));
endmodule

bind pkt_frame_tx pkt_frame_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .out_last(out_last)
);

// File: tb/pkt_frame_tx_bench.sv
`timescale 1ns/1ps
module pkt_frame_tx_bench;
  localparam int MAXP = 256;

  typedef struct packed {
    logic        layout;
    logic        resp;
    logic        ack;
    logic [7:0]  cmd;
    logic [7:0]  snd;
    logic [7:0]  rcv;
    logic [15:0] seq;
    logic [8:0]  plen;
    logic [7:0]  seed;
    logic [3:0]  stall;
    logic [9:0]  exp_len;
  } vec_t;

  localparam vec_t VECS [0:5] = '{
    '{1'b1, 1'b0, 1'b1, 8'h00, 8'h01, 8'hE5, 16'h0001, 9'd0,   8'h11, 4'd0, 10'd12},
    '{1'b1, 1'b1, 1'b0, 8'h01, 8'h22, 8'h33, 16'hA55A, 9'd3,   8'h5C, 4'd2, 10'd15},
    '{1'b0, 1'b0, 1'b1, 8'h02, 8'h44, 8'h55, 16'h1234, 9'd7,   8'hC3, 4'd1, 10'd14},
    '{1'b0, 1'b1, 1'b1, 8'h03, 8'h66, 8'h77, 16'hFFFF, 9'd0,   8'h00, 4'd3, 10'd7},
    '{1'b1, 1'b0, 1'b0, 8'h02, 8'h9A, 8'hBC, 16'h8000, 9'd256, 8'h7E, 4'd0, 10'd268},
    '{1'b0, 1'b1, 1'b0, 8'h09, 8'h10, 8'h20, 16'h0F0F, 9'd256, 8'hA1, 4'd2, 10'd263}
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic       req_valid, req_layout, req_is_resp, req_need_ack, req_ready;
  logic [7:0] req_cmd, req_sender, req_receiver;
  logic [15:0] req_seq;
  logic [8:0] req_plen;
  logic [7:0] pl_raddr, pl_rdata;
  logic       out_valid, out_ready, out_last;
  logic [7:0] out_data;

  logic [7:0] pl_mem [0:MAXP-1];
  logic [7:0] got [0:1023];
  logic [7:0] exp_b [0:1023];
  int         n_got, stall_bad, ready_bad, last_bad;
  int         errors = 0, checks = 0;
  int         cycles = 0;

  always #2.5 clk = ~clk;
  assign pl_rdata = pl_mem[pl_raddr];

  pkt_frame_tx u_pkt_frame_tx (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_layout(req_layout), .req_is_resp(req_is_resp), .req_need_ack(req_need_ack),
    .req_cmd(req_cmd), .req_sender(req_sender), .req_receiver(req_receiver),
    .req_seq(req_seq), .req_plen(req_plen), .pl_raddr(pl_raddr), .pl_rdata(pl_rdata),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last)
  );

  task automatic summary_and_end();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=%0d expected<150000 cycles", cycles);
      summary_and_end();
    end
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] ref_crc8(input int upto);
    logic [7:0] c = 8'hFE;
    for (int i = 0; i < upto; i++)
      for (int b = 7; b >= 0; b--) begin
        logic fb = c[7] ^ exp_b[i][b];
        c = {c[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
      end
    return c;
  endfunction

  function automatic logic [15:0] ref_crc16(input int upto);
    logic [15:0] c = 16'hFEFE;
    for (int i = 0; i < upto; i++)
      for (int b = 7; b >= 0; b--) begin
        logic fb = c[15] ^ exp_b[i][b];
        c = {c[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
      end
    return c;
  endfunction

  task automatic build_exp(input vec_t v);
    int L, h;
    logic [15:0] c16;
    h = v.layout ? 10 : 5;
    L = h + int'(v.plen) + 2;
    for (int k = 0; k < MAXP; k++) pl_mem[k] = v.seed ^ 8'(k * 37);
    exp_b[0] = 8'h55;
    exp_b[1] = L[7:0];
    exp_b[2] = {5'b0, v.layout, L[9:8]};
    exp_b[3] = ref_crc8(3);
    if (v.layout) begin
      exp_b[4] = v.snd; exp_b[5] = v.rcv;
      exp_b[6] = v.seq[15:8]; exp_b[7] = v.seq[7:0];
      exp_b[8] = {v.resp, v.ack, 6'b0}; exp_b[9] = v.cmd;
    end else begin
      exp_b[4] = v.cmd;
    end
    for (int k = 0; k < int'(v.plen); k++) exp_b[h + k] = pl_mem[k];
    c16 = ref_crc16(L - 2);
    exp_b[L-2] = c16[7:0];
    exp_b[L-1] = c16[15:8];
  endtask

  task automatic send_req(input vec_t v);
    @(negedge clk);
    req_valid = 1'b1; req_layout = v.layout; req_is_resp = v.resp; req_need_ack = v.ack;
    req_cmd = v.cmd; req_sender = v.snd; req_receiver = v.rcv; req_seq = v.seq; req_plen = v.plen;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // capture bytes until the final one is accepted or max_beats taken
  task automatic collect(input vec_t v, input int max_beats);
    int  cyc = 0;
    bit  done = 0;
    bit  pend = 0;
    logic [7:0] pd = 8'h00;
    n_got = 0; stall_bad = 0; ready_bad = 0; last_bad = 0;
    while (!done && n_got < max_beats && cyc < 20000) begin
      if (pend && !(out_valid && out_data == pd)) stall_bad++;
      out_ready = (v.stall == 0) || ((cyc % (int'(v.stall) + 1)) != 0);
      #1;
      if (req_ready) ready_bad++;
      if (out_valid && out_ready) begin
        got[n_got] = out_data;
        n_got++;
        if (out_last) done = 1;
        if (!out_last && n_got == int'(v.exp_len)) last_bad++;
      end
      pend = out_valid && !out_ready;
      pd   = out_data;
      @(negedge clk);
      cyc++;
    end
    out_ready = 1'b0;
  endtask

  task automatic run_vec(input vec_t v, input int vi);
    int h, L, bad, first;
    build_exp(v);
    send_req(v);
    collect(v, 1024);
    #1;
    h = v.layout ? 10 : 5;
    L = int'(v.exp_len);
    check(n_got == L && last_bad == 0, "R2", $sformatf("v%0d byte count", vi), n_got, L);
    check(got[1] == exp_b[1] && got[2] == exp_b[2], "R2", $sformatf("v%0d length word", vi),
          {got[2], got[1]}, {exp_b[2], exp_b[1]});
    check(got[0] == 8'h55, "R1", $sformatf("v%0d start byte", vi), got[0], 8'h55);
    check(got[3] == exp_b[3], "R3", $sformatf("v%0d header crc", vi), got[3], exp_b[3]);
    if (v.layout) begin
      check(got[8] == exp_b[8], "R4", $sformatf("v%0d command-type", vi), got[8], exp_b[8]);
      bad = 0;
      for (int i = 4; i < 10; i++) if (got[i] != exp_b[i]) bad++;
      check(bad == 0, "R5", $sformatf("v%0d p2p header mismatches", vi), bad, 0);
    end else begin
      check(got[4] == v.cmd, "R6", $sformatf("v%0d bus cmd id", vi), got[4], v.cmd);
    end
    bad = 0; first = 0;
    for (int i = h; i < L - 2; i++) if (got[i] != exp_b[i]) begin
      if (bad == 0) first = i;
      bad++;
    end
    check(bad == 0, "R7", $sformatf("v%0d payload mismatches (first at %0d)", vi, first), bad, 0);
    check(got[L-2] == exp_b[L-2] && got[L-1] == exp_b[L-1], "R8", $sformatf("v%0d trailer crc", vi),
          {got[L-1], got[L-2]}, {exp_b[L-1], exp_b[L-2]});
    if (v.stall != 0) check(stall_bad == 0, "R9", $sformatf("v%0d stall hold violations", vi), stall_bad, 0);
    check(ready_bad == 0 && req_ready == 1'b1, "R10", $sformatf("v%0d req_ready busy-low/after-high", vi),
          ready_bad, 0);
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; out_ready = 1'b0;
    req_layout = 0; req_is_resp = 0; req_need_ack = 0; req_cmd = 0;
    req_sender = 0; req_receiver = 0; req_seq = 0; req_plen = 0;
    for (int k = 0; k < MAXP; k++) pl_mem[k] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    check(out_valid == 1'b0, "R11", "reset out_valid", out_valid, 0);
    check(req_ready == 1'b1, "R11", "reset req_ready", req_ready, 1);

    for (int vi = 0; vi < 6; vi++) run_vec(VECS[vi], vi);

    // R11: reset in the middle of a frame, then a clean frame
    build_exp(VECS[4]);
    send_req(VECS[4]);
    collect(VECS[4], 20);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    check(out_valid == 1'b0 && req_ready == 1'b1, "R11", "mid-frame reset state",
          {out_valid, req_ready}, 2'b01);
    run_vec(VECS[1], 6);

    summary_and_end();
  end
endmodule